// File: doc/BRIEF.md
# Byte and Halfword Lane Packer with Bit Reversal

This block gathers a stream of bytes, 16-bit halfwords or full 32-bit words into an internal array of 32-bit words, and can split the stored words back out into bytes or halfwords. It keeps one byte-granular pack address. The upper bits of that address select a word of the array and the two lowest bits select a byte lane inside it. Every pack or unpack steers the item to or from the addressed lane or half and then moves the address by the item size. A configuration bit sets whether the address goes up or down.

A second configuration bit reverses the bit order of each item within its own width before it is stored and after it is read. This suits serial peripherals that shift the least significant bit first. Software-side sequencing, the instruction decode and any memory beyond the internal array are handled outside the block.

Top module: `lane_packer`

## Requirements
- R1: While rst_n is low and on the first cycle after reset: addr_rdata is 0, unpack_valid is 0, reversal is off, the direction is increment and every array word reads as zero.
- R2: pack_byte writes pack_data[7:0] into lane addr[1:0] of word addr[AW-1:2], where lane n is bits 8n+7..8n. The other three lanes of that word are preserved. The address moves by one, so after lane 3 filling continues at lane 0 of the next word.
- R3: pack_half writes pack_data[15:0] into bits 15..0 when addr[1] is 0 and into bits 31..16 when addr[1] is 1. addr[0] is ignored. The other half is preserved and the address moves by two.
- R4: pack_word writes all 32 bits of pack_data into word addr[AW-1:2], and the address moves by four.
- R5: A cycle with cfg_we high loads cfg_dec, which takes effect from the next cycle. When it is 1, every step subtracts from the address instead of adding to it.
- R6: A cycle with cfg_we high also loads cfg_rev. When it is 1, bit i of each item moves to bit W-1-i, where W is 8, 16 or 32 for the item size. This applies to items that are packed and to items that are unpacked.
- R7: addr_we loads addr_wdata into the pack address, and the new address appears on addr_rdata in the next cycle.
- R8: unpack_byte returns the addressed lane, and unpack_half returns the addressed half selected by addr[1]. Both are zero-extended on unpack_data in the cycle after the strobe, with unpack_valid high for that cycle only. The address steps exactly as for the matching pack.
- R9: The word index wraps modulo the array depth. Incrementing from address 4*DEPTH-1 gives 0, and decrementing from 0 gives 4*DEPTH-1.
- R10: When several strobes are high in one cycle, only one takes effect. The priority order is addr_we, pack_word, pack_half, pack_byte, unpack_half, unpack_byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Load the configuration bits |
| cfg_rev | input | 1 | Reverse bit order of each item |
| cfg_dec | input | 1 | Step the address downward |
| addr_we | input | 1 | Load the pack address |
| addr_wdata | input | AW (9) | New pack address |
| addr_rdata | output | AW (9) | Current pack address |
| pack_byte | input | 1 | Store one byte and step by 1 |
| pack_half | input | 1 | Store one halfword and step by 2 |
| pack_word | input | 1 | Store one word and step by 4 |
| pack_data | input | 32 | Item to store, right-aligned |
| unpack_byte | input | 1 | Read one byte and step by 1 |
| unpack_half | input | 1 | Read one halfword and step by 2 |
| unpack_data | output | 32 | Zero-extended unpacked item |
| unpack_valid | output | 1 | unpack_data holds a new item |

## Verification
The hardest situations to reach from the ports are a lane write that must leave three neighbour lanes untouched and the wrap of the word index at both ends of the array. Both are visible only through later unpacks from a moved address. The stimulus fills a word byte by byte, moves the address back into the middle of that word and overwrites a single lane. It then reads the word back as halfwords. For the wrap cases it loads the address with the extreme values before a single step, in each direction. Reversal is checked across a configuration change, so that a reversed pack is read back both plainly and reversed.

// File: rtl/lp_pkg.sv
// Shared types and helpers for the lane packer.
// Assumes 32-bit storage words split into four byte lanes.
package lp_pkg;

    typedef enum logic [2:0] {
        OP_NONE, OP_ADDR, OP_PWORD, OP_PHALF, OP_PBYTE, OP_UHALF, OP_UBYTE
    } lp_op_e;

    typedef enum logic [1:0] {SZ_BYTE, SZ_HALF, SZ_WORD} lp_size_e;

    // Item size carried by an operation.
    function automatic lp_size_e op_size(lp_op_e op);
        case (op)
            OP_PHALF, OP_UHALF: return SZ_HALF;
            OP_PWORD:           return SZ_WORD;
            default:            return SZ_BYTE;
        endcase
    endfunction

    // Reverse the bit order inside the item width; bits above it are zero.
    function automatic logic [31:0] rev_item(logic [31:0] d, lp_size_e sz);
        logic [31:0] r;
        r = '0;
        case (sz)
            SZ_BYTE: for (int i = 0; i < 8; i++)  r[i] = d[7-i];
            SZ_HALF: for (int i = 0; i < 16; i++) r[i] = d[15-i];
            default: for (int i = 0; i < 32; i++) r[i] = d[31-i];
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lp_addr_ctrl.sv
// Pack address register: loads on OP_ADDR, otherwise steps by the item
// size of the operation, up or down. Assumes power-of-two array depth so the
// word index wraps naturally with the address width.
module lp_addr_ctrl
    import lp_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  lp_op_e        op,
    input  logic          dec,
    input  logic [AW-1:0] wdata,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] step;
    logic [AW-1:0] next_addr;

    // Step size derived from the operation's item size.
    always_comb begin
        case (op)
            OP_PBYTE, OP_UBYTE: step = AW'(1);
            OP_PHALF, OP_UHALF: step = AW'(2);
            OP_PWORD:           step = AW'(4);
            default:            step = '0;
        endcase
        next_addr = dec ? addr - step : addr + step;
    end

    // Address register update.
    always_ff @(posedge clk) begin
        if (!rst_n)            addr <= '0;
        else if (op == OP_ADDR) addr <= wdata;
        else                    addr <= next_addr;
    end

endmodule

// File: rtl/lp_steer.sv
// Lane steering: places an outgoing item into its byte lanes with byte
// enables, and extracts and formats an item from a stored word. Purely
// combinational; assumes the op is already reduced to one by priority.
module lp_steer
    import lp_pkg::*;
(
    input  lp_op_e      op,
    input  logic [1:0]  lane,
    input  logic        rev,
    input  logic [31:0] wdata,
    input  logic [31:0] rword,
    output logic [3:0]  be,
    output logic [31:0] wword,
    output logic [31:0] rfmt
);

    lp_size_e    sz;
    logic [31:0] item;
    logic [31:0] raw;

    // Write side: optional reversal, replicate, enable the target lanes.
    always_comb begin
        sz   = op_size(op);
        item = rev ? rev_item(wdata, sz) : wdata;
        case (op)
            OP_PBYTE: begin
                wword = {4{item[7:0]}};
                be    = 4'b0001 << lane;
            end
            OP_PHALF: begin
                wword = {2{item[15:0]}};
                be    = lane[1] ? 4'b1100 : 4'b0011;
            end
            OP_PWORD: begin
                wword = item;
                be    = 4'b1111;
            end
            default: begin
                wword = item;
                be    = 4'b0000;
            end
        endcase
    end

    // Read side: select lane or half, zero-extend, optional reversal.
    always_comb begin
        if (op == OP_UHALF) raw = {16'h0, lane[1] ? rword[31:16] : rword[15:0]};
        else                raw = {24'h0, 8'(rword >> {lane, 3'b000})};
        rfmt = rev ? rev_item(raw, sz) : raw;
    end

endmodule

// File: rtl/lp_store.sv
// Word array with per-lane write enables and combinational read of the
// addressed word. Cleared by reset; a lane write touches only its lanes.
module lp_store #(
    parameter int DEPTH = 128,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] idx,
    input  logic [3:0]    be,
    input  logic [31:0]   wword,
    output logic [31:0]   rword
);

    logic [31:0] mem [DEPTH];

    // Lane-masked write, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
        end else begin
            for (int l = 0; l < 4; l++)
                if (be[l]) mem[idx][l*8 +: 8] <= wword[l*8 +: 8];
        end
    end

    assign rword = mem[idx];

endmodule

// File: rtl/lane_packer.sv
// Top of the lane packer: resolves strobe priority into one operation,
// holds the configuration bits and registers unpacked results.
// Assumes DEPTH is a power of two.
module lane_packer
    import lp_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int IW = $clog2(DEPTH),
    localparam int AW = IW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          cfg_rev,
    input  logic          cfg_dec,
    input  logic          addr_we,
    input  logic [AW-1:0] addr_wdata,
    output logic [AW-1:0] addr_rdata,
    input  logic          pack_byte,
    input  logic          pack_half,
    input  logic          pack_word,
    input  logic [31:0]   pack_data,
    input  logic          unpack_byte,
    input  logic          unpack_half,
    output logic [31:0]   unpack_data,
    output logic          unpack_valid
);

    lp_op_e      op;
    logic        cfg_rev_q, cfg_dec_q;
    logic [3:0]  be;
    logic [31:0] wword, rword, rfmt;

    // Priority reduction of the strobes to a single operation.
    always_comb begin
        if      (addr_we)     op = OP_ADDR;
        else if (pack_word)   op = OP_PWORD;
        else if (pack_half)   op = OP_PHALF;
        else if (pack_byte)   op = OP_PBYTE;
        else if (unpack_half) op = OP_UHALF;
        else if (unpack_byte) op = OP_UBYTE;
        else                  op = OP_NONE;
    end

    // Configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_rev_q <= 1'b0;
            cfg_dec_q <= 1'b0;
        end else if (cfg_we) begin
            cfg_rev_q <= cfg_rev;
            cfg_dec_q <= cfg_dec;
        end
    end

    lp_addr_ctrl #(.AW(AW)) addr_i (
        .clk(clk), .rst_n(rst_n), .op(op), .dec(cfg_dec_q),
        .wdata(addr_wdata), .addr(addr_rdata)
    );

    lp_steer steer_i (
        .op(op), .lane(addr_rdata[1:0]), .rev(cfg_rev_q), .wdata(pack_data),
        .rword(rword), .be(be), .wword(wword), .rfmt(rfmt)
    );

    lp_store #(.DEPTH(DEPTH)) store_i (
        .clk(clk), .rst_n(rst_n), .idx(addr_rdata[AW-1:2]), .be(be),
        .wword(wword), .rword(rword)
    );

    // Unpack result register and its one-cycle valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unpack_data  <= '0;
            unpack_valid <= 1'b0;
        end else begin
            unpack_valid <= (op == OP_UHALF) || (op == OP_UBYTE);
            if ((op == OP_UHALF) || (op == OP_UBYTE)) unpack_data <= rfmt;
        end
    end

endmodule

// File: rtl/lp_checker.sv
// Protocol checks for lane_packer, attached by bind.
module lp_checker #(
    parameter int AW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dec,
    input logic          addr_we,
    input logic [AW-1:0] addr_wdata,
    input logic [AW-1:0] addr_rdata,
    input logic          pack_byte,
    input logic          pack_half,
    input logic          pack_word,
    input logic          unpack_byte,
    input logic          unpack_half,
    input logic [31:0]   unpack_data,
    input logic          unpack_valid
);

    logic any_pack;
    assign any_pack = pack_byte || pack_half || pack_word;

    // R7
    addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_we |=> addr_rdata == $past(addr_wdata));

    // R2
    byte_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pack_byte && !addr_we && !pack_half && !pack_word)
        |=> (addr_rdata - $past(addr_rdata)) == ($past(dec) ? {AW{1'b1}} : AW'(1)));

    // R8
    unpack_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unpack_byte && !addr_we && !any_pack) |=> unpack_valid);

    // R8
    valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!unpack_byte && !unpack_half) |=> !unpack_valid);

    // R8
    byte_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unpack_byte && !unpack_half && !addr_we && !any_pack)
        |=> unpack_data[31:8] == 24'h0);

    // R10
    pack_over_unpack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_pack || addr_we) |=> !unpack_valid);

endmodule

bind lane_packer lp_checker #(.AW(AW)) chk_i (
    .clk(clk), .rst_n(rst_n), .dec(cfg_dec_q), .addr_we(addr_we),
    .addr_wdata(addr_wdata), .addr_rdata(addr_rdata), .pack_byte(pack_byte),
    .pack_half(pack_half), .pack_word(pack_word), .unpack_byte(unpack_byte),
    .unpack_half(unpack_half), .unpack_data(unpack_data),
    .unpack_valid(unpack_valid)
);

// File: tb/lane_packer_tb_top.sv
// Scoreboard bench: unpack tasks queue expected items, a monitor pops them.
module lane_packer_tb_top;

    localparam int AW = 9;

    logic          clk = 0, rst_n = 0;
    logic          cfg_we = 0, cfg_rev = 0, cfg_dec = 0;
    logic          addr_we = 0;
    logic [AW-1:0] addr_wdata = '0;
    logic [AW-1:0] addr_rdata;
    logic          pack_byte = 0, pack_half = 0, pack_word = 0;
    logic [31:0]   pack_data = '0;
    logic          unpack_byte = 0, unpack_half = 0;
    logic [31:0]   unpack_data;
    logic          unpack_valid;

    int total = 0, bad = 0;
    logic [31:0] exp_q[$];
    string       req_q[$];

    always #5 clk = ~clk;

    lane_packer dut_i (.*);

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: compare each valid result with the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && unpack_valid) begin
            if (exp_q.size() == 0) check(0, "R8 unexpected valid", unpack_data, 0);
            else begin
                logic [31:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check(unpack_data == e, r, unpack_data, e);
            end
        end
    end

    task automatic set_cfg(bit rev, bit dec);
        cfg_we = 1; cfg_rev = rev; cfg_dec = dec;
        @(negedge clk); cfg_we = 0;
    endtask
    task automatic set_addr(int a);
        addr_we = 1; addr_wdata = AW'(a);
        @(negedge clk); addr_we = 0;
    endtask
    task automatic pk_byte(logic [7:0] d);
        pack_byte = 1; pack_data = {24'hABCDEF, d};
        @(negedge clk); pack_byte = 0;
    endtask
    task automatic pk_half(logic [15:0] d);
        pack_half = 1; pack_data = {16'h9876, d};
        @(negedge clk); pack_half = 0;
    endtask
    task automatic pk_word(logic [31:0] d);
        pack_word = 1; pack_data = d;
        @(negedge clk); pack_word = 0;
    endtask
    task automatic up_byte(logic [31:0] e, string req);
        exp_q.push_back(e); req_q.push_back(req);
        unpack_byte = 1;
        @(negedge clk); unpack_byte = 0;
    endtask
    task automatic up_half(logic [31:0] e, string req);
        exp_q.push_back(e); req_q.push_back(req);
        unpack_half = 1;
        @(negedge clk); unpack_half = 0;
    endtask
    task automatic chk_addr(int e, string req);
        check(addr_rdata == AW'(e), req, 32'(addr_rdata), e);
    endtask

    initial begin
        #(100000 * 10);
        check(0, "watchdog", 0, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(addr_rdata == 0, "R1 addr in reset", 32'(addr_rdata), 0);
        check(unpack_valid == 0, "R1 valid in reset", 32'(unpack_valid), 0);
        rst_n = 1;
        @(negedge clk);
        chk_addr(0, "R1 addr after reset");
        up_byte(32'h0, "R1 array cleared");
        chk_addr(1, "R8 unpack steps");

        // R2 byte fill across a word boundary
        set_addr(0);
        pk_byte(8'h11); pk_byte(8'h22); pk_byte(8'h33); pk_byte(8'h44);
        chk_addr(4, "R2 four bytes advance word");
        pk_byte(8'h55);
        chk_addr(5, "R2 next word lane 0");
        set_addr(0);
        up_byte(32'h11, "R2 lane0"); up_byte(32'h22, "R2 lane1");
        up_byte(32'h33, "R2 lane2"); up_byte(32'h44, "R2 lane3");
        up_half(32'h0055, "R2 new word lane 0");

        // R2 lane preservation
        set_addr(1);
        pk_byte(8'hAA);
        set_addr(0);
        up_half(32'hAA11, "R2 lane1 rewritten lane0 kept");
        up_half(32'h4433, "R2 upper lanes kept");

        // R3 halfword packing, addr[0] ignored
        set_addr(9);
        pk_half(16'h1234);
        chk_addr(11, "R3 half steps by two");
        pk_half(16'h5678);
        set_addr(8);
        up_half(32'h1234, "R3 low half");
        up_half(32'h5678, "R3 high half");
        set_addr(8);
        up_byte(32'h34, "R3 byte of half");

        // R4 word packing
        set_addr(12);
        pk_word(32'hDEADBEEF);
        chk_addr(16, "R4 word steps by four");
        set_addr(12);
        up_byte(32'hEF, "R4 b0"); up_byte(32'hBE, "R4 b1");
        up_byte(32'hAD, "R4 b2"); up_byte(32'hDE, "R4 b3");

        // R6 reversal on pack and unpack
        set_cfg(1, 0);
        set_addr(16);
        pk_byte(8'h01);
        pk_byte(8'h0C);
        set_cfg(0, 0);
        set_addr(16);
        up_byte(32'h80, "R6 reversed byte stored");
        up_byte(32'h30, "R6 reversed byte 0C");
        set_cfg(1, 0);
        set_addr(16);
        up_byte(32'h01, "R6 reversed on unpack");
        set_addr(20);
        pk_half(16'h0001);
        set_cfg(0, 0);
        set_addr(20);
        up_half(32'h8000, "R6 reversed half");

        // R5 decrement direction
        set_cfg(0, 1);
        set_addr(30);
        pk_byte(8'h77);
        chk_addr(29, "R5 byte decrement");
        pk_half(16'hBBCC);
        chk_addr(27, "R5 half decrement");
        set_cfg(0, 0);
        set_addr(28);
        up_half(32'hBBCC, "R5 half at low half");
        up_half(32'h0077, "R5 byte at lane 2");

        // R9 wrap in both directions
        set_addr(511);
        pk_byte(8'h5A);
        chk_addr(0, "R9 increment wrap");
        set_addr(511);
        up_byte(32'h5A, "R9 last lane");
        chk_addr(0, "R9 unpack wrap");
        set_cfg(0, 1);
        set_addr(0);
        pk_byte(8'h3C);
        chk_addr(511, "R9 decrement wrap");
        set_cfg(0, 0);

        // R10 priority
        addr_we = 1; addr_wdata = AW'(40); pack_byte = 1; pack_data = 32'hFF;
        @(negedge clk); addr_we = 0; pack_byte = 0;
        chk_addr(40, "R10 address load wins");
        pack_byte = 1; pack_data = 32'h66; unpack_byte = 1;
        @(negedge clk); pack_byte = 0; unpack_byte = 0;
        check(unpack_valid == 0, "R10 pack over unpack", 32'(unpack_valid), 0);
        chk_addr(41, "R10 one step only");
        set_addr(40);
        up_half(32'h0066, "R10 only pack written");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R8 all results seen", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule